// File: doc/BRIEF.md
# System Clock Source Selector and Divider

This block derives three system clocks (auxiliary, master and subsystem) from six oscillator inputs. Five are raw oscillator levels: low-frequency crystal, very-low-power oscillator, internal reference, digitally controlled oscillator (DCO) and high-frequency crystal. The sixth is a tap that divides the DCO by a power of two. Each clock has its own 3-bit source code and its own 3-bit divider code. The auxiliary clock has a second divider that feeds a copy of it to an external pin. The subsystem clock can be parked low with an off bit.

All logic runs on one fast system clock `clk`. The oscillator inputs arrive already synchronised as levels, and every output is a registered level in that domain. A source change goes through a two-step handshake so that no output ever carries a runt pulse. First the old source is released once it is low. Then the new source is admitted once it is low. A divider ratio change is loaded only when the running count completes a full period of the old ratio.

Configuration comes through a three-word write port. Code 101 selects the high-frequency crystal only while `hfxt_ok` is high; otherwise it selects the divided DCO tap.

Top module: `clk_sys_gen`

## Requirements
- R1: Source codes per clock are 000 low-frequency crystal, 001 very-low-power oscillator, 010 internal reference, 011 DCO, 100 divided DCO tap, 101 high-frequency crystal (when `hfxt_ok`=1).
- R2: Code 101 with `hfxt_ok`=0 routes the divided DCO tap, and the reserved codes 110 and 111 also route the divided DCO tap.
- R3: Divider codes 000..101 divide the selected source by 1, 2, 4, 8, 16, 32; codes 110 and 111 divide by 32.
- R4: `aux_pin_clk` is the auxiliary source divided by its own pin divider code, independent of the auxiliary clock divider.
- R5: The divided DCO tap is `osc_dco` divided by the tap code (same encoding as R3).
- R6: After reset, auxiliary selects code 000 and master and subsystem select code 100. All three clock dividers and the pin divider are 000, the tap code is 001 (DCO/2) and the off bit is 0.
- R7: With the off bit at 1, `sub_clk` finishes its current high phase and then stays low; clearing the bit restores it.
- R8: On a source change the output is held low between releasing the old source and admitting the new one, so no high or low phase is shorter than half the fastest source period.
- R9: A new divider ratio is loaded only when the divider count wraps at the old ratio.
- R10: Writes with `wr_en`=1 decode `wr_addr`. Address 0 holds source codes at bits [2:0] auxiliary, [6:4] master, [10:8] subsystem. Address 1 holds divider codes at the same positions plus the pin divider at [14:12]. Address 2 holds the tap code at [2:0] and the off bit at [8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration word address |
| wr_data | input | 16 | Configuration write data |
| osc_lfxt | input | 1 | Low-frequency crystal level |
| osc_vlo | input | 1 | Very-low-power oscillator level |
| osc_ref | input | 1 | Internal reference oscillator level |
| osc_dco | input | 1 | DCO level |
| osc_hfxt | input | 1 | High-frequency crystal level |
| hfxt_ok | input | 1 | High-frequency crystal valid |
| aux_clk | output | 1 | Auxiliary clock |
| aux_pin_clk | output | 1 | Auxiliary copy for the external pin |
| mst_clk | output | 1 | Master clock |
| sub_clk | output | 1 | Subsystem clock |

## Verification
The bench builds the block with its default parameters: six sources, 3-bit codes and a 5-bit count that reaches divide by 32. The oscillator models use half periods of 2 to 28 fast cycles. With these values every source code, every divider code (including the spare ones) and the 32-way tap each produce an output period of at most a few hundred fast cycles, so periods can be compared exactly. A run-length monitor on the master clock covers every switch the bench makes. It catches any phase shorter than the fastest source's half period, which is where a broken handshake or an early ratio reload would show.

// File: rtl/clksys_pkg.sv
package clksys_pkg;

    localparam int SRC_N        = 6;
    localparam int SEL_W        = 3;
    localparam int MAX_LOG      = 5;
    localparam int CH_N         = 3;
    localparam int ADDR_W       = 2;
    localparam int DATA_W       = 16;
    localparam int FIELD_STRIDE = 4;
    localparam int PIN_LSB      = 12;
    localparam int OFF_BIT      = 8;
    localparam int DIV_N        = CH_N + 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_LFXT   = 3'd0,
        SRC_VLO    = 3'd1,
        SRC_REF    = 3'd2,
        SRC_DCO    = 3'd3,
        SRC_DCODIV = 3'd4,
        SRC_HFXT   = 3'd5,
        SRC_RSV6   = 3'd6,
        SRC_RSV7   = 3'd7
    } src_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEL  = 2'd0,
        REG_DIV  = 2'd1,
        REG_MISC = 2'd2,
        REG_NONE = 2'd3
    } reg_e;

    typedef enum logic [1:0] {
        SW_RUN    = 2'd0,
        SW_DROP   = 2'd1,
        SW_ENGAGE = 2'd2
    } sw_state_e;

    typedef logic [CH_N-1:0][SEL_W-1:0] chcode_t;

    function automatic logic [SEL_W-1:0] div_log(input logic [SEL_W-1:0] code);
        return (code > SEL_W'(MAX_LOG)) ? SEL_W'(MAX_LOG) : code;
    endfunction

    function automatic logic [SEL_W-1:0] route_src(input logic [SEL_W-1:0] code,
                                                   input logic hf_ok);
        logic [SEL_W-1:0] r;
        case (src_e'(code))
            SRC_HFXT: r = hf_ok ? SRC_HFXT : SRC_DCODIV;
            SRC_RSV6,
            SRC_RSV7: r = SRC_DCODIV;
            default:  r = code;
        endcase
        return r;
    endfunction

    function automatic logic [SEL_W-1:0] chan_reset_sel(input int ch);
        return (ch == 0) ? SRC_LFXT : SRC_DCODIV;
    endfunction

endpackage

// File: rtl/clk_glitchless_mux.sv
module clk_glitchless_mux
    import clksys_pkg::*;
#(
    parameter int              N       = 6,
    parameter int              IW      = 3,
    parameter logic [IW-1:0]   RST_SEL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src,
    input  logic [IW-1:0] want,
    output logic          out,
    output logic          parked,
    output logic [IW-1:0] active
);
    localparam int PAD = 1 << IW;

    logic [PAD-1:0] src_ext;
    logic [IW-1:0]  cur;
    logic           gate;
    sw_state_e      st;

    assign src_ext = PAD'(src);
    assign parked  = ~gate;
    assign active  = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= RST_SEL;
            gate <= 1'b1;
            st   <= SW_RUN;
            out  <= 1'b0;
        end else begin
            out <= gate & src_ext[cur];
            case (st)
                SW_RUN: begin
                    if (want != cur) st <= SW_DROP;
                end
                SW_DROP: begin
                    if (!src_ext[cur]) begin
                        gate <= 1'b0;
                        cur  <= want;
                        st   <= SW_ENGAGE;
                    end
                end
                SW_ENGAGE: begin
                    if (!src_ext[cur]) begin
                        gate <= 1'b1;
                        st   <= SW_RUN;
                    end
                end
                default: st <= SW_RUN;
            endcase
        end
    end
endmodule

// File: rtl/clk_pow2_div.sv
module clk_pow2_div
    import clksys_pkg::*;
#(
    parameter int MAX_L = 5,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in,
    input  logic [CW-1:0]    code,
    output logic             out,
    output logic [CW-1:0]    ratio_log,
    output logic [MAX_L-1:0] phase
);
    logic             prev;
    logic [CW-1:0]    act, act_n;
    logic [MAX_L-1:0] cnt, cnt_n, nxt, mask;
    logic [MAX_L:0]   taps;

    always_comb begin
        act_n = act;
        cnt_n = cnt;
        nxt   = cnt + 1'b1;
        mask  = MAX_L'((32'd1 << act) - 32'd1);
        if (in && !prev) begin
            if ((nxt & mask) == '0) begin
                act_n = CW'(div_log(SEL_W'(code)));
                cnt_n = '0;
            end else begin
                cnt_n = nxt;
            end
        end
        taps = {cnt_n, in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            act  <= '0;
            cnt  <= '0;
            out  <= 1'b0;
        end else begin
            prev <= in;
            act  <= act_n;
            cnt  <= cnt_n;
            out  <= taps[act_n];
        end
    end

    assign ratio_log = act;
    assign phase     = cnt;
endmodule

// File: rtl/clk_sys_gen.sv
module clk_sys_gen
    import clksys_pkg::*;
#(
    parameter logic [SEL_W-1:0] TAP_RST_CODE = 3'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              osc_lfxt,
    input  logic              osc_vlo,
    input  logic              osc_ref,
    input  logic              osc_dco,
    input  logic              osc_hfxt,
    input  logic              hfxt_ok,
    output logic              aux_clk,
    output logic              aux_pin_clk,
    output logic              mst_clk,
    output logic              sub_clk
);
    chcode_t          sel_q, div_q;
    logic [SEL_W-1:0] pin_div_q, tap_div_q;
    logic             sub_off_q, off_act;
    logic             unused_wd;

    logic [SRC_N-1:0]                 src_vec;
    logic                             dco_tap;
    logic [CH_N-1:0]                  ch_src, ch_div, ch_parked;
    chcode_t                          ch_active;
    logic [DIV_N-1:0][SEL_W-1:0]      div_logs;
    logic [DIV_N-1:0][MAX_LOG-1:0]    div_phases;

    assign unused_wd = ^{wr_data[15], wr_data[11], wr_data[7], wr_data[3]};

    // configuration words (R10, reset values R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int ch = 0; ch < CH_N; ch++) begin
                sel_q[ch] <= chan_reset_sel(ch);
                div_q[ch] <= '0;
            end
            pin_div_q <= '0;
            tap_div_q <= TAP_RST_CODE;
            sub_off_q <= 1'b0;
        end else if (wr_en) begin
            case (reg_e'(wr_addr))
                REG_SEL: begin
                    for (int ch = 0; ch < CH_N; ch++)
                        sel_q[ch] <= wr_data[ch*FIELD_STRIDE +: SEL_W];
                end
                REG_DIV: begin
                    for (int ch = 0; ch < CH_N; ch++)
                        div_q[ch] <= wr_data[ch*FIELD_STRIDE +: SEL_W];
                    pin_div_q <= wr_data[PIN_LSB +: SEL_W];
                end
                REG_MISC: begin
                    tap_div_q <= wr_data[SEL_W-1:0];
                    sub_off_q <= wr_data[OFF_BIT];
                end
                default: ;
            endcase
        end
    end

    // divided DCO tap (R5)
    clk_pow2_div #(.MAX_L(MAX_LOG), .CW(SEL_W)) u_tap (
        .clk(clk), .rst(rst), .in(osc_dco), .code(tap_div_q),
        .out(dco_tap), .ratio_log(div_logs[CH_N]), .phase(div_phases[CH_N])
    );

    assign src_vec = {osc_hfxt, dco_tap, osc_dco, osc_ref, osc_vlo, osc_lfxt};

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
        logic [SEL_W-1:0] route;
        assign route = route_src(sel_q[ch], hfxt_ok);

        clk_glitchless_mux #(
            .N(SRC_N), .IW(SEL_W), .RST_SEL(chan_reset_sel(ch))
        ) u_mux (
            .clk(clk), .rst(rst), .src(src_vec), .want(route),
            .out(ch_src[ch]), .parked(ch_parked[ch]), .active(ch_active[ch])
        );

        clk_pow2_div #(.MAX_L(MAX_LOG), .CW(SEL_W)) u_div (
            .clk(clk), .rst(rst), .in(ch_src[ch]), .code(div_q[ch]),
            .out(ch_div[ch]), .ratio_log(div_logs[ch]), .phase(div_phases[ch])
        );
    end

    // external pin copy of the auxiliary source (R4)
    clk_pow2_div #(.MAX_L(MAX_LOG), .CW(SEL_W)) u_pin (
        .clk(clk), .rst(rst), .in(ch_src[0]), .code(pin_div_q),
        .out(aux_pin_clk), .ratio_log(div_logs[CH_N+1]), .phase(div_phases[CH_N+1])
    );

    // subsystem park: the off request is taken only while the clock is low (R7)
    always_ff @(posedge clk) begin
        if (rst)             off_act <= 1'b0;
        else if (!ch_div[2]) off_act <= sub_off_q;
    end

    assign aux_clk = ch_div[0];
    assign mst_clk = ch_div[1];
    assign sub_clk = ch_div[2] & ~off_act;
endmodule

// File: rtl/clk_sys_gen_chk.sv
module clk_sys_gen_chk
    import clksys_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic [CH_N-1:0]               ch_parked,
    input logic [CH_N-1:0]               ch_src,
    input chcode_t                       ch_active,
    input chcode_t                       sel_q,
    input logic [DIV_N-1:0][SEL_W-1:0]   div_logs,
    input logic [DIV_N-1:0][MAX_LOG-1:0] div_phases,
    input logic                          sub_off_q,
    input logic                          sub_clk
);
    for (genvar ch = 0; ch < CH_N; ch++) begin : g_sel
        a_r8_parked_silent: assert property (@(posedge clk) disable iff (rst)
            ch_parked[ch] |=> !ch_src[ch]);
        a_r1_active_legal: assert property (@(posedge clk) disable iff (rst)
            ch_active[ch] < SEL_W'(SRC_N));
    end

    for (genvar d = 0; d < DIV_N; d++) begin : g_div
        a_r9_reload_at_wrap: assert property (@(posedge clk) disable iff (rst)
            !$stable(div_logs[d]) |-> div_phases[d] == '0);
    end

    a_r7_off_holds_low: assert property (@(posedge clk) disable iff (rst)
        (sub_off_q && !sub_clk) |=> !sub_clk);

    a_r6_reset_sources: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_q[0] == SRC_LFXT && sel_q[1] == SRC_DCODIV
                        && sel_q[2] == SRC_DCODIV));
endmodule

bind clk_sys_gen clk_sys_gen_chk u_chk (
    .clk(clk), .rst(rst), .ch_parked(ch_parked), .ch_src(ch_src),
    .ch_active(ch_active), .sel_q(sel_q), .div_logs(div_logs),
    .div_phases(div_phases), .sub_off_q(sub_off_q), .sub_clk(sub_clk)
);

// File: tb/tb_clk_sys_gen.sv
`timescale 1ns/1ps
module tb_clk_sys_gen;
    localparam int HALF_LFXT = 20, HALF_VLO = 28, HALF_REF = 12;
    localparam int HALF_DCO  = 2,  HALF_HFXT = 6;
    localparam int NV = 9;
    // {master source code, master divider code, expected master period}
    localparam int VEC [NV][3] = '{
        '{0, 0, 40}, '{1, 1, 112}, '{2, 2, 96}, '{3, 3, 32}, '{4, 0, 8},
        '{5, 1, 24}, '{3, 6, 128}, '{7, 0, 8}, '{2, 5, 768}
    };
    localparam string VTAG [NV] = '{"R1", "R1", "R1", "R3", "R1", "R1", "R3", "R2", "R3"};

    logic clk = 0, rst = 1, wr_en = 0;
    logic [1:0]  wr_addr = 0;
    logic [15:0] wr_data = 0;
    logic osc_lfxt = 0, osc_vlo = 0, osc_ref = 0, osc_dco = 0, osc_hfxt = 0;
    logic hfxt_ok = 1;
    logic aux_clk, aux_pin_clk, mst_clk, sub_clk;

    int checks = 0, errors = 0;
    int min_run = 1 << 30, run_len = 0;
    logic run_en = 0, last_m = 0;
    logic [2:0] s_aux = 0, s_mst = 4, s_sub = 4;
    logic [2:0] d_aux = 0, d_mst = 0, d_sub = 0, d_pin = 0, tap = 1;
    logic off = 0;

    clk_sys_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .osc_lfxt(osc_lfxt), .osc_vlo(osc_vlo), .osc_ref(osc_ref), .osc_dco(osc_dco),
        .osc_hfxt(osc_hfxt), .hfxt_ok(hfxt_ok), .aux_clk(aux_clk),
        .aux_pin_clk(aux_pin_clk), .mst_clk(mst_clk), .sub_clk(sub_clk)
    );

    always #10 clk = ~clk;

    initial forever begin repeat (HALF_LFXT) @(negedge clk); osc_lfxt = ~osc_lfxt; end
    initial forever begin repeat (HALF_VLO)  @(negedge clk); osc_vlo  = ~osc_vlo;  end
    initial forever begin repeat (HALF_REF)  @(negedge clk); osc_ref  = ~osc_ref;  end
    initial forever begin repeat (HALF_DCO)  @(negedge clk); osc_dco  = ~osc_dco;  end
    initial forever begin repeat (HALF_HFXT) @(negedge clk); osc_hfxt = ~osc_hfxt; end

    // master clock phase-length monitor (R8)
    initial forever begin
        @(negedge clk);
        if (run_en) begin
            if (mst_clk == last_m) run_len++;
            else begin
                if (run_len > 0 && run_len < min_run) min_run = run_len;
                run_len = 1;
            end
        end
        last_m = mst_clk;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic push_all();
        wr(2'd0, {5'd0, s_sub, 1'b0, s_mst, 1'b0, s_aux});
        wr(2'd1, {1'b0, d_pin, 1'b0, d_sub, 1'b0, d_mst, 1'b0, d_aux});
        wr(2'd2, {7'd0, off, 5'd0, tap});
    endtask

    function automatic logic pick(input int w);
        case (w)
            0: return aux_clk;
            1: return mst_clk;
            2: return sub_clk;
            default: return aux_pin_clk;
        endcase
    endfunction

    task automatic wait_rise(input int w, output int n);
        logic p, c;
        n = 0;
        p = pick(w);
        forever begin
            @(negedge clk); n++;
            c = pick(w);
            if ((c && !p) || n > 5000) break;
            p = c;
        end
    endtask

    task automatic period(input int w, output int per);
        int n;
        for (int k = 0; k < 3; k++) wait_rise(w, n);
        wait_rise(w, per);
        if (per > 5000) per = -1;
    endtask

    initial begin
        int per, rises;
        logic p, c;
        repeat (5) @(negedge clk);
        rst = 0;
        run_en = 1;

        // R6: reset selections and dividers
        period(0, per); check("R6 aux after reset", per, 40);
        period(1, per); check("R6 mst after reset", per, 8);
        period(2, per); check("R6 sub after reset", per, 8);

        for (int i = 0; i < NV; i++) begin
            s_mst = 3'(VEC[i][0]); d_mst = 3'(VEC[i][1]);
            push_all();
            period(1, per);
            check(VTAG[i], per, VEC[i][2]);
        end

        // R9: shrink ratio from /32 to /2 on the DCO, period follows the new ratio
        s_mst = 3; d_mst = 5; push_all(); period(1, per);
        d_mst = 1; push_all(); period(1, per);
        check("R9 ratio reload", per, 8);

        // R5: tap code 3 gives DCO/8
        tap = 3; s_mst = 4; d_mst = 0; push_all();
        period(1, per); check("R5 dco tap /8", per, 32);

        // R2: crystal invalid falls back to the tap
        hfxt_ok = 0; s_mst = 5; push_all();
        period(1, per); check("R2 hfxt fallback", per, 32);
        hfxt_ok = 1;
        period(1, per); check("R1 hfxt restored", per, 12);

        // R4: pin divider independent of aux divider
        s_aux = 1; d_aux = 2; d_pin = 0; push_all();
        period(0, per); check("R4 aux /4", per, 224);
        period(3, per); check("R4 pin /1", per, 56);

        // R7: subsystem park
        s_sub = 3; d_sub = 1; push_all();
        period(2, per); check("R7 sub running", per, 8);
        off = 1; push_all();
        repeat (20) @(negedge clk);
        rises = 0; p = sub_clk;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk); c = sub_clk;
            if (c && !p) rises++;
            p = c;
        end
        check("R7 sub parked edges", rises, 0);
        check("R7 sub parked level", int'(sub_clk), 0);
        off = 0; push_all();
        period(2, per); check("R7 sub resumed", per, 8);

        // R10: a write to the unused address changes nothing
        wr(2'd3, 16'hFFFF);
        period(1, per); check("R10 unused address", per, 12);

        // R8: shortest master phase over all switches
        check("R8 min phase", (min_run >= HALF_DCO) ? 1 : 0, 1);
        if (min_run < HALF_DCO) $display("  shortest phase %0d", min_run);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule